// File: doc/BRIEF.md
# Serial Clock Event Counter

This block is a small wrap-around event counter that sits next to a serial shift register and counts the same clock events that move it. The events come from one of three sources, chosen by a two-bit select: a software strobe, an overflow pulse from a neighbouring 8-bit timer, or an asynchronous external serial clock. The external clock is synchronised first. Both of its edges then count as events.

When the 4-bit count wraps from its maximum back to zero, a sticky overflow flag is set. If the host has enabled it, the flag also raises an interrupt request. Each wrap also drives a carry pulse one system clock wide. That pulse can clock an external 8-bit timer, so the pair forms a 12-bit counter. Loading the counter with its maximum value makes the next single event overflow it. In the external mode this turns the flag into an extra edge-triggered interrupt. In the software mode it turns the flag into a software interrupt.

Top module: `serclk_evt_counter`

## Requirements
- R1: Each selected event raises the 4-bit count by one. The count wraps from 15 to 0, and it holds its value in any cycle without an event or a write.
- R2: A wrap sets the overflow flag. The flag then stays set until the host pulses `flag_clr_i`.
- R3: `irq_o` is high exactly when the overflow flag is set and `irq_en_i` is high.
- R4: The select codes on `src_sel_i` are: 0 for the software strobe, 1 for the timer overflow, and 2 or 3 for the external clock. With the external clock selected, both its rising and its falling edges count, each after synchronisation.
- R5: Sources that are not selected have no effect on the count.
- R6: A host write via `cnt_wr_i` loads `cnt_wdata_i` and takes priority over an event in the same cycle. That event is lost, and it causes no wrap and no carry.
- R7: When a wrap and a flag-clear pulse fall in the same cycle, the flag ends up set.
- R8: `carry_o` is high for exactly one cycle after each wrap. During that cycle the count reads 0.
- R9: After a preset to 15, a single event sets the flag and, if enabled, the interrupt request.
- R10: After reset, the count is 0 and the flag, `irq_o` and `carry_o` are all low.
- R11: When an 8-bit counter is clocked by `carry_o`, {that counter, count} equals the total number of events modulo 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel_i | input | 2 | Event source select (0 strobe, 1 timer, 2/3 external) |
| sw_strobe_i | input | 1 | Software clock strobe, one cycle per event |
| tmr_ovf_i | input | 1 | Timer overflow pulse, one cycle per event |
| ext_clk_i | input | 1 | Asynchronous external serial clock |
| cnt_wr_i | input | 1 | Host write of the count |
| cnt_wdata_i | input | 4 | Value loaded by a host write |
| flag_clr_i | input | 1 | Host clear of the overflow flag |
| irq_en_i | input | 1 | Overflow interrupt enable |
| cnt_o | output | 4 | Current count |
| flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |
| carry_o | output | 1 | One-cycle carry pulse per wrap |

## Verification
Two pairs of functions can land in the same cycle. In the first, a host load meets a counting event. The bench provokes it by raising the strobe and the write together while the count is 15, and then expects the written value with no carry and no flag. In the second, a flag clear meets a wrap. The bench provokes it by pulsing the clear alongside the wrapping strobe, and then judges that the flag is still set. Around these collisions, the bench sweeps every preset against 0 to 17 events for both pulse sources and computes the count and flag arithmetically.

// File: rtl/sce_pkg.sv
package sce_pkg;

  typedef enum logic [1:0] {
    SRC_STROBE = 2'd0,
    SRC_TIMER  = 2'd1,
    SRC_EXT_A  = 2'd2,
    SRC_EXT_B  = 2'd3
  } src_sel_e;

  // next count value for a counter of the given width
  function automatic int unsigned cnt_next(int unsigned v, int unsigned w);
    return (v + 1) % (32'd1 << w);
  endfunction

  // true when the value is the last one before the wrap
  function automatic logic cnt_at_top(int unsigned v, int unsigned w);
    return v == ((32'd1 << w) - 1);
  endfunction

endpackage

// File: rtl/sce_edge_sync.sv
module sce_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic edge_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[LAST];
    end
  end

  // any change of level is an event: both edges count
  assign edge_o = sync_q[LAST] ^ prev_q;
endmodule

// File: rtl/sce_evt_select.sv
module sce_evt_select
  import sce_pkg::*;
(
  input  src_sel_e sel_i,
  input  logic     sw_strobe_i,
  input  logic     tmr_ovf_i,
  input  logic     ext_edge_i,
  output logic     evt_o
);
  always_comb begin
    unique case (sel_i)
      SRC_STROBE:          evt_o = sw_strobe_i;
      SRC_TIMER:           evt_o = tmr_ovf_i;
      SRC_EXT_A, SRC_EXT_B: evt_o = ext_edge_i;
      default:             evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sce_count_core.sv
module sce_count_core
  import sce_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             carry_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             carry_q;
  logic             step;

  assign step    = evt_i && !wr_i;
  assign cnt_inc = CNT_W'(cnt_next(int'(cnt_q), CNT_W));
  assign wrap_o  = step && cnt_at_top(int'(cnt_q), CNT_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      carry_q <= wrap_o;
      if (wr_i)      cnt_q <= wdata_i;
      else if (step) cnt_q <= cnt_inc;
    end
  end

  assign cnt_o   = cnt_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/sce_ovf_flag.sv
module sce_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;
endmodule

// File: rtl/serclk_evt_counter.sv
module serclk_evt_counter
  import sce_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel_i,
  input  logic             sw_strobe_i,
  input  logic             tmr_ovf_i,
  input  logic             ext_clk_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             carry_o
);
  // named internal events, observed by the checker
  logic ext_edge;
  logic count_evt;
  logic wrap_evt;

  sce_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(ext_clk_i), .edge_o(ext_edge)
  );

  sce_evt_select sel_i (
    .sel_i(src_sel_e'(src_sel_i)), .sw_strobe_i(sw_strobe_i),
    .tmr_ovf_i(tmr_ovf_i), .ext_edge_i(ext_edge), .evt_o(count_evt)
  );

  sce_count_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .evt_i(count_evt), .wr_i(cnt_wr_i),
    .wdata_i(cnt_wdata_i), .cnt_o(cnt_o), .wrap_o(wrap_evt), .carry_o(carry_o)
  );

  sce_ovf_flag flag_i (
    .clk(clk), .rst_n(rst_n), .set_i(wrap_evt), .clr_i(flag_clr_i),
    .en_i(irq_en_i), .flag_o(flag_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/serclk_evt_counter_chk.sv
module serclk_evt_counter_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic             carry_o,
  input logic             irq_en_i,
  input logic             flag_clr_i,
  input logic             cnt_wr_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic             count_evt,
  input logic             wrap_evt
);
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    count_evt && !cnt_wr_i |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !count_evt && !cnt_wr_i |=> $stable(cnt_o)); // R1
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag_o); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !flag_clr_i |=> flag_o); // R2
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_en_i && flag_o); // R3
  AST_IRQ_WHEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && irq_en_i |-> irq_o); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> cnt_o == $past(cnt_wdata_i) && !carry_o); // R6
  AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt && flag_clr_i |=> flag_o); // R7
  AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=> !carry_o); // R8
  AST_CARRY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> cnt_o == '0); // R8
endmodule

bind serclk_evt_counter serclk_evt_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_o(cnt_o), .flag_o(flag_o), .irq_o(irq_o),
  .carry_o(carry_o), .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
  .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i), .count_evt(count_evt),
  .wrap_evt(wrap_evt)
);

// File: tb/serclk_evt_counter_tb_top.sv
`timescale 1ns/1ps
module serclk_evt_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] src_sel_i = 2'd0;
  logic       sw_strobe_i = 1'b0, tmr_ovf_i = 1'b0, ext_clk_i = 1'b0;
  logic       cnt_wr_i = 1'b0;
  logic [3:0] cnt_wdata_i = 4'd0;
  logic       flag_clr_i = 1'b0, irq_en_i = 1'b0;
  logic [3:0] cnt_o;
  logic       flag_o, irq_o, carry_o;

  int checks = 0;
  int errors = 0;
  int hi8 = 0;   // bench model of the cascaded 8-bit timer
  bit done = 0;

  always #5 clk = ~clk;

  serclk_evt_counter dut_i (
    .clk(clk), .rst_n(rst_n), .src_sel_i(src_sel_i), .sw_strobe_i(sw_strobe_i),
    .tmr_ovf_i(tmr_ovf_i), .ext_clk_i(ext_clk_i), .cnt_wr_i(cnt_wr_i),
    .cnt_wdata_i(cnt_wdata_i), .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i),
    .cnt_o(cnt_o), .flag_o(flag_o), .irq_o(irq_o), .carry_o(carry_o)
  );

  always @(negedge clk) if (carry_o) hi8 = (hi8 + 1) % 256;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_sw();
    @(negedge clk) sw_strobe_i = 1'b1;
    @(negedge clk) sw_strobe_i = 1'b0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk) tmr_ovf_i = 1'b1;
    @(negedge clk) tmr_ovf_i = 1'b0;
  endtask

  task automatic toggle_ext();
    @(negedge clk) ext_clk_i = ~ext_clk_i;
    repeat (4) @(negedge clk);
  endtask

  task automatic load(int v);
    @(negedge clk) begin cnt_wr_i = 1'b1; cnt_wdata_i = 4'(v); end
    @(negedge clk) cnt_wr_i = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr_i = 1'b1;
    @(negedge clk) flag_clr_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 cnt", cnt_o, 0);
    check("R10 flag", flag_o, 0);
    check("R10 irq", irq_o, 0);
    check("R10 carry", carry_o, 0);
    @(negedge clk) rst_n = 1'b1;

    // R1 R2 sweep: every preset against 0..17 events, strobe then timer
    for (int s = 0; s < 2; s++) begin
      src_sel_i = 2'(s);
      for (int p = 0; p < 16; p++) begin
        for (int n = 0; n < 18; n++) begin
          clear_flag();
          load(p);
          for (int k = 0; k < n; k++) begin
            if (s == 0) pulse_sw(); else pulse_tmr();
          end
          check("R1 sweep count", cnt_o, (p + n) % 16);
          check("R2 sweep flag", flag_o, (p + n) >= 16 ? 1 : 0);
        end
      end
    end

    // R2 flag sticks over further events, then clears
    src_sel_i = 2'd0;
    load(15); pulse_sw(); pulse_sw(); pulse_sw();
    check("R2 sticky", flag_o, 1);
    clear_flag();
    check("R2 cleared", flag_o, 0);

    // R3 interrupt gating
    load(15); pulse_sw();
    check("R3 irq disabled", irq_o, 0);
    @(negedge clk) irq_en_i = 1'b1;
    #1 check("R3 irq enabled", irq_o, 1);
    clear_flag();
    check("R3 irq after clear", irq_o, 0);

    // R4 external clock, both edges, codes 2 and 3
    for (int s = 2; s < 4; s++) begin
      src_sel_i = 2'(s);
      load(0);
      for (int e = 1; e <= 20; e++) begin
        toggle_ext();
        check("R4 ext edge count", cnt_o, e % 16);
      end
    end

    // R5 unselected sources ignored
    src_sel_i = 2'd0; load(5);
    pulse_tmr(); toggle_ext();
    check("R5 strobe mode ignores others", cnt_o, 5);
    src_sel_i = 2'd1; load(6);
    pulse_sw(); toggle_ext();
    check("R5 timer mode ignores others", cnt_o, 6);
    src_sel_i = 2'd2; load(7);
    pulse_sw(); pulse_tmr();
    check("R5 ext mode ignores others", cnt_o, 7);

    // R6 write beats event at the top value
    src_sel_i = 2'd0; clear_flag(); load(15);
    @(negedge clk) begin cnt_wr_i = 1'b1; cnt_wdata_i = 4'd3; sw_strobe_i = 1'b1; end
    @(negedge clk) begin cnt_wr_i = 1'b0; sw_strobe_i = 1'b0; end
    check("R6 written value", cnt_o, 3);
    check("R6 no carry", carry_o, 0);
    check("R6 no flag", flag_o, 0);

    // R7 wrap and clear together
    load(15); pulse_sw(); load(15);
    @(negedge clk) begin sw_strobe_i = 1'b1; flag_clr_i = 1'b1; end
    @(negedge clk) begin sw_strobe_i = 1'b0; flag_clr_i = 1'b0; end
    check("R7 set wins", flag_o, 1);

    // R8 carry width
    clear_flag(); load(15);
    @(negedge clk) sw_strobe_i = 1'b1;
    @(negedge clk) sw_strobe_i = 1'b0;
    check("R8 carry high", carry_o, 1);
    check("R8 count zero", cnt_o, 0);
    @(negedge clk) check("R8 carry low", carry_o, 0);

    // R9 single external edge as an interrupt
    clear_flag(); src_sel_i = 2'd3; irq_en_i = 1'b1; load(15);
    check("R9 no irq before edge", irq_o, 0);
    toggle_ext();
    check("R9 flag after edge", flag_o, 1);
    check("R9 irq after edge", irq_o, 1);
    irq_en_i = 1'b0;

    // R11 12-bit cascade with a modelled 8-bit timer
    src_sel_i = 2'd1; load(0); hi8 = 0;
    for (int k = 0; k < 1000; k++) pulse_tmr();
    check("R11 cascade total", hi8 * 16 + int'(cnt_o), 1000 % 4096);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule